// File: doc/BRIEF.md
# Differential alert handshake link

This block holds both ends of a point-to-point alert channel: a sender that sits next to the logic raising an alert, and a receiver that sits next to the logic collecting it. Three complementary wire pairs join the two ends. The alert pair runs from sender to receiver. The acknowledge pair and the line-test pair run back from receiver to sender. The wires leave and re-enter the block through ports, so the physical channel between the two ends stays outside the block.

The sender turns a level-sensitive request into four-phase handshakes and repeats them while the request stays high. The receiver reports each alert with a one-cycle pulse. On a request from a central scheduler it also line-tests the sender: it toggles the line-test pair and waits for a handshake in reply. Both ends watch their incoming pairs for complementarity faults. A sender that sees a fault reports it by breaking the alert pair's encoding on purpose.

The parameter `ASYNC` puts a two-flop synchronizer on every incoming pair, for use when the two ends run on unrelated clocks.

Top module: `alert_link`

## Requirements
- R1: After reset every pair idles with its p wire at 0 and its n wire at 1, and `triggered_o`, `ping_ok_o` and `integ_fail_o` are all 0.
- R2: Each handshake runs in four phases. The sender raises the alert level, the receiver then raises the acknowledge level, the sender then drops the alert level, and the receiver then drops the acknowledge level.
- R3: Each alert handshake raises `triggered_o` for exactly one cycle, as soon as the raised alert level is seen. A request sampled high on L consecutive cycles gives 1 handshake when L is 1, and 2 + floor((L-2)/P) handshakes otherwise. P is the spacing between handshake starts: 6 cycles when `ASYNC`=0 and 14 cycles when `ASYNC`=1. This spacing includes a 2-cycle pause after each handshake.
- R4: A rising edge on `ping_req_i` toggles the line-test pair. The sender answers with a handshake, and the receiver then gives a one-cycle `ping_ok_o` and no `triggered_o`.
- R5: If a line-test toggle and an alert request reach an idle sender in the same cycle, the sender answers the line test first and sends the alert afterwards. The result is one `ping_ok_o`, followed later by one `triggered_o`.
- R6: If an alert handshake is already running when a line-test toggle reaches the sender, the receiver counts that handshake as the line-test reply. The sender then runs a further handshake, which the receiver reports as `triggered_o`. The result is one `ping_ok_o`, followed later by one `triggered_o`.
- R7: If the alert pair at the receiver is equal on two consecutive samples, `integ_fail_o` is asserted and the acknowledge level is forced to 0.
- R8: If the sender sees its acknowledge or line-test pair equal on two consecutive samples, it drives both alert wires to one common value and inverts that value every cycle. The receiver then asserts `integ_fail_o`.
- R9: An equal state on a pair that lasts only one sample is treated as skew. It never raises a fault, and the level change it delays is still delivered.
- R10: Once a fault clears, both ends go back to idle levels, `integ_fail_o` drops, and the next alert is delivered normally.
- R11: With `ASYNC`=1 each incoming pair crosses two extra flops. The delay from request to `triggered_o` is 4 cycles, against 2 cycles with `ASYNC`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alert_req_i | input | 1 | Level alert request at the sender |
| tx_alert_p_o | output | 1 | Sender alert pair, p wire |
| tx_alert_n_o | output | 1 | Sender alert pair, n wire |
| tx_ack_p_i | input | 1 | Acknowledge pair as it arrives at the sender, p wire |
| tx_ack_n_i | input | 1 | Acknowledge pair as it arrives at the sender, n wire |
| tx_ping_p_i | input | 1 | Line-test pair as it arrives at the sender, p wire |
| tx_ping_n_i | input | 1 | Line-test pair as it arrives at the sender, n wire |
| rx_alert_p_i | input | 1 | Alert pair as it arrives at the receiver, p wire |
| rx_alert_n_i | input | 1 | Alert pair as it arrives at the receiver, n wire |
| rx_ack_p_o | output | 1 | Receiver acknowledge pair, p wire |
| rx_ack_n_o | output | 1 | Receiver acknowledge pair, n wire |
| rx_ping_p_o | output | 1 | Receiver line-test pair, p wire |
| rx_ping_n_o | output | 1 | Receiver line-test pair, n wire |
| ping_req_i | input | 1 | Line-test request; a rising edge starts one test |
| ping_ok_o | output | 1 | One-cycle pulse when the line-test reply completes |
| triggered_o | output | 1 | One-cycle pulse per received alert |
| integ_fail_o | output | 1 | Alert pair encoding fault seen at the receiver |

## Verification
The assertions check the local protocol rules on every cycle:
- the acknowledge level rises only after the alert level has risen;
- the sender drops the alert level only when it sees an acknowledge, or when a fault occurs;
- a detected fault takes the sender into its fault state at once and forces the receiver's acknowledge low;
- a pending line test always wins over an alert at the start of a handshake.

Other behaviours show only at the ports over many cycles, and so only the bench scenarios can show them:
- the handshake count for each request length and the spacing set by `ASYNC`;
- the order of `ping_ok_o` and `triggered_o` in both collision cases;
- tolerance of one-sample skew;
- the toggling fault pattern and the recovery that follows it.

// File: rtl/alert_link.sv
module alert_link #(
  parameter bit ASYNC = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alert_req_i,
  output logic tx_alert_p_o,
  output logic tx_alert_n_o,
  input  logic tx_ack_p_i,
  input  logic tx_ack_n_i,
  input  logic tx_ping_p_i,
  input  logic tx_ping_n_i,
  input  logic rx_alert_p_i,
  input  logic rx_alert_n_i,
  output logic rx_ack_p_o,
  output logic rx_ack_n_o,
  output logic rx_ping_p_o,
  output logic rx_ping_n_o,
  input  logic ping_req_i,
  output logic ping_ok_o,
  output logic triggered_o,
  output logic integ_fail_o
);
  localparam int NPAIR = 3;
  localparam logic [2*NPAIR-1:0] IDLE_LVL = {NPAIR{2'b01}};

  logic [2*NPAIR-1:0] raw, syn;
  assign raw = {tx_ack_p_i, tx_ack_n_i, tx_ping_p_i, tx_ping_n_i, rx_alert_p_i, rx_alert_n_i};

  if (ASYNC) begin : g_sync
    logic [2*NPAIR-1:0] m1, m2;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        m1 <= IDLE_LVL;
        m2 <= IDLE_LVL;
      end else begin
        m1 <= raw;
        m2 <= m1;
      end
    assign syn = m2;
  end else begin : g_direct
    assign syn = raw;
  end

  // pair 0: ack at sender, pair 1: ping at sender, pair 2: alert at receiver
  logic [NPAIR-1:0] sp, sn, mis, mis_q, lvl, lvl_q, flt;
  for (genvar k = 0; k < NPAIR; k++) begin : g_dec
    assign sp[k]  = syn[2*NPAIR-1-2*k];
    assign sn[k]  = syn[2*NPAIR-2-2*k];
    assign mis[k] = sp[k] == sn[k];
    assign lvl[k] = mis[k] ? lvl_q[k] : sp[k];
    assign flt[k] = mis[k] & mis_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lvl_q <= '0;
      mis_q <= '0;
    end else begin
      lvl_q <= lvl;
      mis_q <= mis;
    end

  // sender
  typedef enum logic [2:0] {T_IDLE, T_AHI, T_ALO, T_PHI, T_PLO, T_PS0, T_PS1, T_SIG} tst_e;
  tst_e st, st_d;
  logic ping_pq, stk_q, tog_q;
  logic t_sig, ping_ev, ping_pend, pend_a, start_a, ping_done, tx_hi, can_start;

  assign t_sig     = flt[0] | flt[1];
  assign ping_ev   = lvl[1] ^ lvl_q[1];
  assign ping_pend = ping_pq | ping_ev;
  assign pend_a    = alert_req_i | stk_q;
  assign can_start = (st == T_IDLE) || (st == T_PS1);
  assign start_a   = can_start & ~t_sig & ~ping_pend & pend_a;
  assign ping_done = (st == T_PLO) & ~lvl[0];

  always_comb begin
    st_d = st;
    if (t_sig) st_d = T_SIG;
    else case (st)
      T_IDLE, T_PS1: st_d = ping_pend ? T_PHI : (pend_a ? T_AHI : T_IDLE);
      T_AHI:   if (lvl[0])  st_d = T_ALO;
      T_ALO:   if (!lvl[0]) st_d = T_PS0;
      T_PHI:   if (lvl[0])  st_d = T_PLO;
      T_PLO:   if (!lvl[0]) st_d = T_PS0;
      T_PS0:   st_d = T_PS1;
      default: st_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st      <= T_IDLE;
      ping_pq <= 1'b0;
      stk_q   <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      st      <= st_d;
      tog_q   <= (st == T_SIG) ? ~tog_q : 1'b0;
      stk_q   <= start_a ? 1'b0 : (stk_q | alert_req_i);
      ping_pq <= t_sig ? 1'b0 : (ping_ev | (ping_pq & ~ping_done));
    end

  assign tx_hi        = (st == T_AHI) || (st == T_PHI);
  assign tx_alert_p_o = (st == T_SIG) ? tog_q : tx_hi;
  assign tx_alert_n_o = (st == T_SIG) ? tog_q : ~tx_hi;

  // receiver
  logic ack_q, ping_q, preq_q, pw_q, hsp_q, trig_q, pok_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      ping_q <= 1'b0;
      preq_q <= 1'b0;
      pw_q   <= 1'b0;
      hsp_q  <= 1'b0;
      trig_q <= 1'b0;
      pok_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      pok_q  <= 1'b0;
      preq_q <= ping_req_i;
      if (flt[2]) begin
        ack_q <= 1'b0;
        hsp_q <= 1'b0;
      end else if (!ack_q && lvl[2]) begin
        ack_q  <= 1'b1;
        hsp_q  <= pw_q;
        trig_q <= ~pw_q;
      end else if (ack_q && !lvl[2]) begin
        ack_q <= 1'b0;
        pok_q <= hsp_q;
        if (hsp_q) pw_q <= 1'b0;
      end
      if (ping_req_i && !preq_q && !flt[2]) begin
        ping_q <= ~ping_q;
        pw_q   <= 1'b1;
      end
    end

  assign rx_ack_p_o   = ack_q;
  assign rx_ack_n_o   = ~ack_q;
  assign rx_ping_p_o  = ping_q;
  assign rx_ping_n_o  = ~ping_q;
  assign triggered_o  = trig_q;
  assign ping_ok_o    = pok_q;
  assign integ_fail_o = flt[2];

  a_r2_ack_after_alert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(lvl[2]));
  a_r2_alert_waits_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_hi) |-> ($past(lvl[0]) || $past(t_sig)));
  a_r8_fault_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_sig |=> (st == T_SIG));
  a_r7_fault_drops_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt[2] |=> !ack_q);
  a_r4_pok_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pok_q |=> !pok_q);
  a_r5_ping_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (can_start && ping_pend && !t_sig) |=> (st == T_PHI));
  a_r10_fault_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == T_SIG && !t_sig) |=> (st == T_IDLE));
endmodule

// File: tb/tb_alert_link.sv
`timescale 1ns/1ps
module tb_alert_link;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] req = 2'b00;
  logic preq = 1'b0, f_an = 1'b0, s_an = 1'b0, f_kn = 1'b0, s_pn = 1'b0;
  wire [1:0] tap, tan, kp, kn, pp, pn, trig, pok, integ;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ntrig[2] = '{0, 0};
  int nok[2]   = '{0, 0};
  int nint[2]  = '{0, 0};
  int tcyc[2]  = '{0, 0};
  int ocyc[2]  = '{0, 0};

  for (genvar g = 0; g < 2; g++) begin : g_cfg
    logic d_an = 1'b1, d_pn = 1'b1;
    always @(posedge clk) begin
      d_an <= tan[g];
      d_pn <= pn[g];
    end
    wire ran = f_an ? tap[g] : (s_an ? d_an : tan[g]);
    wire kni = f_kn ? kp[g] : kn[g];
    wire pni = s_pn ? d_pn : pn[g];

    alert_link #(.ASYNC(1'(g))) dut (
      .clk_i(clk), .rst_ni(rst_n), .alert_req_i(req[g]),
      .tx_alert_p_o(tap[g]), .tx_alert_n_o(tan[g]),
      .tx_ack_p_i(kp[g]), .tx_ack_n_i(kni),
      .tx_ping_p_i(pp[g]), .tx_ping_n_i(pni),
      .rx_alert_p_i(tap[g]), .rx_alert_n_i(ran),
      .rx_ack_p_o(kp[g]), .rx_ack_n_o(kn[g]),
      .rx_ping_p_o(pp[g]), .rx_ping_n_o(pn[g]),
      .ping_req_i(preq), .ping_ok_o(pok[g]),
      .triggered_o(trig[g]), .integ_fail_o(integ[g]));

    always @(negedge clk) if (rst_n) begin
      if (trig[g])  begin ntrig[g] <= ntrig[g] + 1; tcyc[g] <= cyc; end
      if (pok[g])   begin nok[g] <= nok[g] + 1;     ocyc[g] <= cyc; end
      if (integ[g]) nint[g] <= nint[g] + 1;
    end
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int bt[2], bo[2], bi[2];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic snap();
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      bt[c] = ntrig[c]; bo[c] = nok[c]; bi[c] = nint[c];
    end
    tick(1);
  endtask

  function automatic int per(input int c);
    return (c == 1) ? 14 : 6;
  endfunction

  task automatic one_alert();
    req = 2'b11; tick(1); req = 2'b00; tick(60);
  endtask

  task automatic one_ping();
    preq = 1'b1; tick(60); preq = 1'b0; tick(2);
  endtask

  initial begin
    int c0;
    tick(5);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R1 idle wire levels", {tap[c], tan[c], kp[c], kn[c], pp[c], pn[c]}, 6'b010101);
      chk("R1 idle outputs", {trig[c], pok[c], integ[c]}, 0);
    end
    tick(3);

    // R3 / R11: request length sweep
    for (int len = 1; len <= 24; len++) begin
      snap();
      c0 = cyc;
      req = 2'b11;
      tick(len);
      req = 2'b00;
      tick(70);
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        chk($sformatf("R3 handshakes len=%0d cfg=%0d", len, c), ntrig[c] - bt[c],
            (len < 2) ? 1 : 2 + (len - 2) / per(c));
        chk("R3 no ping_ok during alerts", nok[c] - bo[c], 0);
        if (len == 1)
          chk($sformatf("R11 request to trigger latency cfg=%0d", c), tcyc[c] - c0, (c == 1) ? 4 : 2);
      end
      tick(1);
    end

    // R4: line tests
    snap();
    repeat (3) one_ping();
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R4 ping_ok count", nok[c] - bo[c], 3);
      chk("R4 no trigger for pings", ntrig[c] - bt[c], 0);
    end
    tick(1);

    // R5: ping and alert reach the sender together
    snap();
    preq = 1'b1; tick(1);
    req[0] = 1'b1; tick(1);
    req[0] = 1'b0; tick(1);
    req[1] = 1'b1; tick(1);
    req[1] = 1'b0; tick(80);
    preq = 1'b0; tick(2);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R5 ping_ok count", nok[c] - bo[c], 1);
      chk("R5 trigger count", ntrig[c] - bt[c], 1);
      chk("R5 ping_ok before trigger", int'(ocyc[c] < tcyc[c]), 1);
    end
    tick(1);

    // R6: alert handshake already running when ping arrives
    snap();
    preq = 1'b1; req = 2'b11; tick(1);
    req = 2'b00; tick(80);
    preq = 1'b0; tick(2);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R6 ping_ok count", nok[c] - bo[c], 1);
      chk("R6 trigger count", ntrig[c] - bt[c], 1);
      chk("R6 ping_ok before trigger", int'(ocyc[c] < tcyc[c]), 1);
    end
    tick(1);

    // R9: one-cycle skew on alert pair and on ping pair
    snap();
    s_an = 1'b1; tick(1);
    one_alert();
    s_an = 1'b0; s_pn = 1'b1; tick(1);
    one_ping();
    s_pn = 1'b0; tick(2);
    f_an = 1'b1; tick(1); f_an = 1'b0; tick(5);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R9 skewed alert delivered", ntrig[c] - bt[c], 1);
      chk("R9 skewed ping answered", nok[c] - bo[c], 1);
      chk("R9 no integrity fault", nint[c] - bi[c], 0);
    end
    tick(1);

    // R7 / R10: stuck alert wire at receiver
    f_an = 1'b1; tick(5);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R7 integ_fail on equal alert pair", integ[c], 1);
      chk("R7 ack held low", {kp[c], kn[c]}, 2'b01);
    end
    tick(1);
    f_an = 1'b0; tick(8);
    snap();
    one_alert();
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R10 integ_fail cleared", integ[c], 0);
      chk("R10 alert after recovery", ntrig[c] - bt[c], 1);
    end
    tick(1);

    // R8 / R10: ack wire fault seen by sender
    f_kn = 1'b1; tick(9);
    begin
      logic [1:0] v;
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        chk("R8 alert wires equal", int'(tap[c] == tan[c]), 1);
        chk("R8 receiver integ_fail", integ[c], 1);
      end
      v = tap;
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
        chk("R8 alert wires toggle", tap[c], !v[c]);
        chk("R8 still equal", int'(tap[c] == tan[c]), 1);
      end
    end
    tick(1);
    f_kn = 1'b0; tick(20);
    snap();
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R10 idle levels after fault", {tap[c], tan[c], kp[c], kn[c], integ[c]}, 5'b01010);
    end
    tick(1);
    one_alert();
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      chk("R10 alert after sender fault", ntrig[c] - bt[c], 1);
      chk("R10 no fault after recovery", nint[c] - bi[c], 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule